// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor

This block chooses the address an instruction-fetch stage will request on the following cycle. It looks up the current fetch address in two small tables that share one index, taken from address bits [5:2]. A direct-mapped target cache holds a valid bit, an upper-address tag and a stored jump destination for each slot. A direction table holds one 2-bit saturating counter for each slot. The lookup is purely combinational, so the choice is ready in the same cycle as the fetch address.

The block predicts taken only when the target cache holds a matching entry and the counter's upper bit is set. In that case the next address is the stored destination; in every other case it is the current address plus four. A later pipeline stage that finds a wrong guess drives a redirect with the correct address. The redirect beats any prediction in that cycle and raises a flush so that the wrongly fetched instruction turns into a no-op.

When a branch resolves, an update port trains the tables. A taken outcome fills the cache slot with tag and destination and moves the counter one step toward taken. A not-taken outcome moves the counter one step toward not-taken and leaves the cache slot alone. Updates become visible to lookups on the next cycle.

Top module: `fetch_npc_predictor`

## Requirements
- R1: After reset every target-cache slot is invalid and every counter holds 01 (weakly not-taken), so every lookup predicts not-taken.
- R2: When no redirect is present and no taken prediction is made, next_pc equals cur_pc + 4 (modulo 2^32).
- R3: When the slot at cur_pc[5:2] is valid, its tag equals cur_pc[31:6] and its counter is 10 or 11, pred_taken is 1 and next_pc is the stored destination.
- R4: A target-cache miss (slot invalid or tag mismatch) gives pred_taken 0 and next_pc = cur_pc + 4, whatever the counter at that slot holds.
- R5: Each counter saturates: a taken update at 11 leaves 11, a not-taken update at 00 leaves 00; otherwise it moves by one. Its upper bit is the direction (1 = taken).
- R6: When redirect_valid is 1, next_pc equals redirect_pc, flush is 1 and pred_taken is 0, even if a taken prediction would otherwise be made.
- R7: flush is 0 in every cycle in which redirect_valid is 0.
- R8: An update takes effect at the next rising clock edge; a lookup in the same cycle sees the old state. A taken update writes tag upd_pc[31:6] and destination upd_target into slot upd_pc[5:2] and marks it valid; a not-taken update leaves that slot's valid bit, tag and destination unchanged.
- R9: Addresses that share bits [5:2] but differ in bits [31:6] share one counter and one cache slot; bits [1:0] take no part in indexing or tagging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | Address being fetched this cycle |
| redirect_valid | input | 1 | Later stage found a wrong guess |
| redirect_pc | input | 32 | Correct address to fetch next |
| upd_valid | input | 1 | A resolved branch trains the tables this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved destination |
| next_pc | output | 32 | Address to fetch on the next cycle |
| pred_taken | output | 1 | next_pc is a predicted destination |
| flush | output | 1 | Turn the wrongly fetched instruction into a no-op |

## Verification
A wrong counter value or a corrupted cache slot shows at the ports the first time that slot is looked up after the faulty update: pred_taken and next_pc disagree with a model that replays every update. The counter ends are reached through directed runs of repeated same-direction updates, so an off-by-one saturation flips the prediction within one or two cycles of the extra update. Aliasing between addresses that share an index shows as a counter trained by one address steering the prediction for another, while a tag fault shows as a taken prediction for an address that never wrote the slot.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // One saturating step of a 2-bit direction counter.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) begin
      res = (cur == CTR_STRONG_T) ? cur : cur + 2'b01;
    end else begin
      res = (cur == CTR_STRONG_NT) ? cur : cur - 2'b01;
    end
    return res;
  endfunction

endpackage

// File: rtl/npc_dir_table.sv
module npc_dir_table
  import npc_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        rd_idx,
  output ctr_t                    rd_ctr,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    wr_taken,
  output logic [2*(1<<IDX_W)-1:0] ctr_flat
);

  localparam int ENTRIES = 1 << IDX_W;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ctr
    ctr_t ctr_q;
    ctr_t ctr_d;
    logic ctr_en;

    assign ctr_en = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      ctr_d = ctr_step(ctr_q, wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctr_q <= CTR_WEAK_NT;
      end else if (ctr_en) begin
        ctr_q <= ctr_d;
      end
    end

    assign ctr_flat[2*i +: 2] = ctr_q;
  end

  assign rd_ctr = ctr_flat[{rd_idx, 1'b0} +: 2];

endmodule

// File: rtl/npc_tgt_cache.sv
module npc_tgt_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_target,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target
);

  localparam int ENTRIES = 1 << IDX_W;

  logic              vld_arr [ENTRIES];
  logic [TAG_W-1:0]  tag_arr [ENTRIES];
  logic [ADDR_W-1:0] tgt_arr [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic              slot_en;
    logic              vld_q;
    logic              vld_d;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] tgt_q;

    assign slot_en = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      vld_d = vld_q | slot_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
      end
    end

    // Payload needs no reset: it is qualified by the valid bit.
    always_ff @(posedge clk) begin
      if (slot_en) begin
        tag_q <= wr_tag;
        tgt_q <= wr_target;
      end
    end

    assign vld_arr[i] = vld_q;
    assign tag_arr[i] = tag_q;
    assign tgt_arr[i] = tgt_q;
  end

  assign rd_hit    = vld_arr[rd_idx] && (tag_arr[rd_idx] == rd_tag);
  assign rd_target = tgt_arr[rd_idx];

endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              hit,
  input  logic              dir_taken,
  input  logic [ADDR_W-1:0] target,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pred_taken,
  output logic              flush
);

  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] seq_pc;
  logic              guess;

  assign seq_pc = cur_pc + INSN_BYTES;
  assign guess  = hit && dir_taken;

  always_comb begin
    next_pc    = seq_pc;
    pred_taken = 1'b0;
    flush      = 1'b0;
    if (redirect_valid) begin
      next_pc = redirect_pc;
      flush   = 1'b1;
    end else if (guess) begin
      next_pc    = target;
      pred_taken = 1'b1;
    end
  end

endmodule

// File: rtl/fetch_npc_predictor.sv
module fetch_npc_predictor
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pred_taken,
  output logic              flush
);

  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  // Reset: asserted at once, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]        lk_idx;
  logic [TAG_W-1:0]        lk_tag;
  logic [IDX_W-1:0]        up_idx;
  logic [TAG_W-1:0]        up_tag;
  logic                    lk_hit;
  logic [ADDR_W-1:0]       lk_target;
  ctr_t                    lk_ctr;
  logic [2*(1<<IDX_W)-1:0] ctr_flat;
  logic                    cache_wr;
  logic                    unused_low_bits;

  assign lk_idx   = cur_pc[TAG_LO-1:IDX_LO];
  assign lk_tag   = cur_pc[ADDR_W-1:TAG_LO];
  assign up_idx   = upd_pc[TAG_LO-1:IDX_LO];
  assign up_tag   = upd_pc[ADDR_W-1:TAG_LO];
  assign cache_wr = upd_valid && upd_taken;
  assign unused_low_bits = ^upd_pc[IDX_LO-1:0];

  npc_tgt_cache #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W)
  ) u_cache (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_idx    (lk_idx),
    .rd_tag    (lk_tag),
    .rd_hit    (lk_hit),
    .rd_target (lk_target),
    .wr_en     (cache_wr),
    .wr_idx    (up_idx),
    .wr_tag    (up_tag),
    .wr_target (upd_target)
  );

  npc_dir_table #(
    .IDX_W (IDX_W)
  ) u_dir (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (up_idx),
    .wr_taken (upd_taken),
    .ctr_flat (ctr_flat)
  );

  npc_select #(
    .ADDR_W (ADDR_W)
  ) u_sel (
    .cur_pc         (cur_pc),
    .hit            (lk_hit),
    .dir_taken      (lk_ctr[1]),
    .target         (lk_target),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .next_pc        (next_pc),
    .pred_taken     (pred_taken),
    .flush          (flush)
  );

endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       cur_pc,
  input logic                    redirect_valid,
  input logic [ADDR_W-1:0]       redirect_pc,
  input logic                    upd_valid,
  input logic [ADDR_W-1:0]       upd_pc,
  input logic                    upd_taken,
  input logic [ADDR_W-1:0]       next_pc,
  input logic                    pred_taken,
  input logic                    flush,
  input logic                    lk_hit,
  input logic [2*(1<<IDX_W)-1:0] ctr_flat
);

  logic [IDX_W-1:0] upd_idx;
  logic [IDX_W-1:0] last_idx_q;
  logic             last_hi_q;
  logic             last_lo_q;

  assign upd_idx = upd_pc[IDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx_q <= '0;
      last_hi_q  <= 1'b0;
      last_lo_q  <= 1'b0;
    end else begin
      last_idx_q <= upd_idx;
      last_hi_q  <= upd_valid && upd_taken  && (ctr_flat[{upd_idx, 1'b0} +: 2] == 2'b11);
      last_lo_q  <= upd_valid && !upd_taken && (ctr_flat[{upd_idx, 1'b0} +: 2] == 2'b00);
    end
  end

  AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (next_pc == redirect_pc) && flush && !pred_taken); // R6

  AST_NO_SPURIOUS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_valid |-> !flush); // R7

  AST_SEQ_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_valid && !pred_taken) |-> (next_pc == cur_pc + ADDR_W'(4))); // R2

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> lk_hit); // R4

  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    last_hi_q |-> (ctr_flat[{last_idx_q, 1'b0} +: 2] == 2'b11)); // R5

  AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    last_lo_q |-> (ctr_flat[{last_idx_q, 1'b0} +: 2] == 2'b00)); // R5

endmodule

bind fetch_npc_predictor npc_checker #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cur_pc         (cur_pc),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .upd_valid      (upd_valid),
  .upd_pc         (upd_pc),
  .upd_taken      (upd_taken),
  .next_pc        (next_pc),
  .pred_taken     (pred_taken),
  .flush          (flush),
  .lk_hit         (lk_hit),
  .ctr_flat       (ctr_flat)
);

// File: tb/fetch_npc_predictor_tb.sv
`timescale 1ns/1ps
module fetch_npc_predictor_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] cur_pc;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic [31:0] upd_target;
  logic [31:0] next_pc;
  logic        pred_taken;
  logic        flush;

  int total;
  int bad;
  bit done;

  // Reference state, built from the requirements.
  bit          m_vld [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];
  logic [1:0]  m_ctr [16];

  fetch_npc_predictor u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cur_pc         (cur_pc),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .upd_valid      (upd_valid),
    .upd_pc         (upd_pc),
    .upd_taken      (upd_taken),
    .upd_target     (upd_target),
    .next_pc        (next_pc),
    .pred_taken     (pred_taken),
    .flush          (flush)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit exp_pred(input logic [31:0] pc);
    int i;
    i = int'(pc[5:2]);
    return m_vld[i] && (m_tag[i] == pc[31:6]) && m_ctr[i][1];
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] pc, input bit rv,
                                           input logic [31:0] rpc);
    if (rv) return rpc;
    if (exp_pred(pc)) return m_tgt[int'(pc[5:2])];
    return pc + 32'd4;
  endfunction

  function automatic logic [1:0] step(input logic [1:0] c, input bit t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // One cycle: drive at the falling edge, check the combinational outputs,
  // then let the rising edge take the update and mirror it in the model.
  task automatic cyc(input string req, input logic [31:0] pc, input bit rv,
                     input logic [31:0] rpc, input bit uv, input logic [31:0] upc,
                     input bit ut, input logic [31:0] utgt);
    int ui;
    @(negedge clk);
    cur_pc = pc; redirect_valid = rv; redirect_pc = rpc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
    #1;
    check(req, "next_pc", next_pc, exp_next(pc, rv, rpc));
    check(req, "pred_taken", {31'd0, pred_taken}, {31'd0, (!rv) && exp_pred(pc)});
    check(req, "flush", {31'd0, flush}, {31'd0, rv});
    @(posedge clk);
    if (uv) begin
      ui = int'(upc[5:2]);
      m_ctr[ui] = step(m_ctr[ui], ut);
      if (ut) begin
        m_vld[ui] = 1'b1;
        m_tag[ui] = upc[31:6];
        m_tgt[ui] = utgt;
      end
    end
  endtask

  task automatic look(input string req, input logic [31:0] pc);
    cyc(req, pc, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 32'd0);
  endtask

  task automatic train(input string req, input logic [31:0] upc, input bit ut,
                       input logic [31:0] utgt);
    cyc(req, 32'h0000_0f00, 1'b0, 32'd0, 1'b1, upc, ut, utgt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] pa;
    logic [31:0] pb;
    logic [25:0] pool [4];
    void'($urandom(32'd20250611));
    total = 0; bad = 0; done = 1'b0;
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'b01;
    end
    rst_n = 1'b0;
    cur_pc = '0; redirect_valid = 1'b0; redirect_pc = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state gives sequential fetch everywhere
    for (int i = 0; i < 16; i++) look("R1", 32'h0000_1000 + 32'(i * 4));
    // R2: wrap of the sequential adder
    look("R2", 32'hffff_fffc);

    pa = 32'h0000_1234;             // index 0xD
    pb = pa + 32'h0000_0040;        // same index, other tag (R9)
    // R8: same-cycle lookup sees old state
    cyc("R8", pa, 1'b0, 32'd0, 1'b1, pa, 1'b1, 32'h0000_8000);
    // R3: counter 10 and hit -> stored destination
    look("R3", pa);
    // R4 and R9: aliasing address misses on tag though counter is taken
    look("R4", pb);
    look("R9", pa | 32'h3);
    // R6: redirect wins over a taken prediction
    cyc("R6", pa, 1'b1, 32'h0000_4444, 1'b0, 32'd0, 1'b0, 32'd0);
    // R7: no flush without redirect
    look("R7", pa);
    // R5: drive to 00 and beyond, then back up
    train("R5", pa, 1'b0, 32'd0);
    train("R5", pa, 1'b0, 32'd0);
    train("R5", pa, 1'b0, 32'd0);
    look("R5", pa);
    train("R5", pa, 1'b1, 32'h0000_9000);
    look("R5", pa);
    train("R5", pa, 1'b1, 32'h0000_9000);
    look("R5", pa);
    // R5: saturate at 11, one not-taken keeps taken; R8: target untouched
    train("R5", pa, 1'b1, 32'h0000_9000);
    train("R5", pa, 1'b1, 32'h0000_9000);
    train("R8", pa, 1'b0, 32'hdead_beef);
    look("R8", pa);
    train("R5", pa, 1'b0, 32'd0);
    look("R5", pa);
    // R9: other address at same index takes over the slot
    train("R9", pb, 1'b1, 32'h0000_a000);
    look("R9", pb);
    look("R9", pa);

    // Random traffic over a small tag pool to provoke hits and aliasing.
    pool[0] = 26'h000_0004; pool[1] = 26'h000_0005;
    pool[2] = 26'h3ff_ff00; pool[3] = 26'h012_3456;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] rp;
      logic [31:0] up;
      rp = {pool[$urandom % 4], 4'($urandom), 2'($urandom)};
      up = {pool[$urandom % 4], 4'($urandom), 2'($urandom)};
      cyc("R3", rp, ($urandom % 10) == 0, $urandom, ($urandom % 2) == 0, up,
          ($urandom % 10) < 6, $urandom);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule